// File: doc/BRIEF.md
# OUT endpoint interrupt status roll-up

This block holds the interrupt status for four OUT endpoints of a device controller. The endpoint logic reports events to it as single-cycle pulses. The block latches each event into a sticky bit in that endpoint's status word, and software clears the bits by writing ones to them.

The status words are combined with a per-endpoint enable mask to form a summary word, with one bit per endpoint. The summary bits are then ORed into a single interrupt line for all OUT endpoints. Clearing the status bits therefore also clears the summary bits and the interrupt line.

Endpoint 0 is the control endpoint. It also counts back-to-back SETUP packets and flags a run that grows longer than three packets.

A flat register port gives read access and write-one-to-clear access. Reads return data combinationally from the address. Writes take effect at the clock edge.

Top module: `out_ep_irq_rollup`

## Requirements
- R1: After reset, each endpoint status word reads 0x0000_0080. The status word for endpoint n sits at byte address 0xB08 + n*0x20. Bit 7 always reads 1 and is not writable. All other bits of the word read 0 after reset. The summary word at 0x818 reads 0, the mask word at 0x81C reads 0, and `out_irq` is low. Both the summary and mask words carry endpoint n in bit 16+n.
- R2: Bit 0 (transfer done) of endpoint n is set only once both the bus-side pulse and the USB-side pulse for that endpoint have been seen. The two pulses may arrive in either order or in the same cycle.
- R3: An endpoint-disabled pulse sets bit 1, and a setup-end pulse sets bit 3. Each bit is readable in the cycle after the pulse's clock edge.
- R4: A set status bit stays set until software writes a 1 to that bit at that endpoint's address. The following writes leave the bits unchanged: writing 0, writing to another address, and writing to the reserved bits 2, 5 and 7.
- R5: If an event pulse and a write-one-to-clear hit the same bit at the same edge, the bit stays set.
- R6: An OUT-token pulse sets bit 4 of endpoint n only when `ep_enabled[n]` is low.
- R7: Endpoint 0 counts back-to-back SETUP packets. The SETUP pulse that arrives after three uninterrupted SETUP packets sets bit 6 of endpoint 0. Bit 6 of endpoints 1 to 3 always reads 0.
- R8: The SETUP count returns to zero in two cases: on a non-SETUP token on endpoint 0, and on the setup-end pulse of endpoint 0.
- R9: Summary bit 16+n is the OR of endpoint n's status bits ANDed with mask bit 16+n. `out_irq` is the OR of all summary bits. Both follow a status clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_enabled | input | 4 | Endpoint n is enabled |
| xfer_bus_done | input | 4 | Bus-side completion pulse per endpoint |
| xfer_usb_done | input | 4 | USB-side completion pulse per endpoint |
| ep_disabled_ev | input | 4 | Endpoint disabled pulse |
| setup_end_ev | input | 4 | SETUP phase finished pulse |
| out_tok_ev | input | 4 | OUT token received pulse |
| ctl_setup_ev | input | 1 | SETUP packet received on endpoint 0 |
| ctl_other_tok_ev | input | 1 | Non-SETUP token on endpoint 0 |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (ones clear status bits) |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| out_irq | output | 1 | Combined OUT endpoint interrupt |

## Verification
Each status bit is directly readable, so a latched bit that is wrong shows up at the next read of that endpoint's word. The same fault reaches `out_irq` in the cycle after the faulty edge, as long as the endpoint is unmasked.

A SETUP counter that is wrong stays hidden until the next SETUP burst. It then shows up as bit 6 rising one packet early or one packet late. For that reason the tests probe the third and fourth packet of a run after each way of restarting the count.

A half-transfer tracker that is wrong shows up only when the second half of the transfer arrives. It appears as bit 0 being set too early, or never being set.

// File: rtl/out_ep_irq_rollup.sv
module out_ep_irq_rollup #(
  parameter int N_EP      = 4,
  parameter int ADDR_W    = 12,
  parameter int B2B_LIMIT = 3,
  parameter int EP_BASE   = 'hB08,
  parameter int EP_STRIDE = 'h20,
  parameter int SUM_ADDR  = 'h818,
  parameter int MSK_ADDR  = 'h81C,
  parameter int SUM_LSB   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EP-1:0]   ep_enabled,
  input  logic [N_EP-1:0]   xfer_bus_done,
  input  logic [N_EP-1:0]   xfer_usb_done,
  input  logic [N_EP-1:0]   ep_disabled_ev,
  input  logic [N_EP-1:0]   setup_end_ev,
  input  logic [N_EP-1:0]   out_tok_ev,
  input  logic              ctl_setup_ev,
  input  logic              ctl_other_tok_ev,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              out_irq
);
  localparam int CW = $clog2(B2B_LIMIT + 1);
  localparam logic [6:0] IMPL = 7'b1011011;

  logic [6:0]          stat [N_EP];
  logic [N_EP*7-1:0]   stat_flat;
  logic                bus_seen [N_EP];
  logic                usb_seen [N_EP];
  logic [N_EP-1:0]     msk;
  logic [N_EP-1:0]     sum;
  logic [CW-1:0]       b2b_cnt;
  logic                b2b_hit;

  assign b2b_hit = ctl_setup_ev && (b2b_cnt == CW'(B2B_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)
      b2b_cnt <= '0;
    else if (setup_end_ev[0] || ctl_other_tok_ev)
      b2b_cnt <= '0;
    else if (ctl_setup_ev && b2b_cnt != CW'(B2B_LIMIT))
      b2b_cnt <= b2b_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      msk <= '0;
    else if (reg_wr && reg_addr == ADDR_W'(MSK_ADDR))
      msk <= reg_wdata[SUM_LSB +: N_EP];
  end

  for (genvar n = 0; n < N_EP; n++) begin : g_ep
    logic       hit;
    logic       xfer;
    logic [6:0] setv;
    logic [6:0] clrv;

    assign hit  = reg_wr && reg_addr == ADDR_W'(EP_BASE + n * EP_STRIDE);
    assign xfer = (bus_seen[n] | xfer_bus_done[n]) & (usb_seen[n] | xfer_usb_done[n]);
    assign clrv = hit ? (reg_wdata[6:0] & IMPL) : 7'b0;

    always_comb begin
      setv    = '0;
      setv[0] = xfer;
      setv[1] = ep_disabled_ev[n];
      setv[3] = setup_end_ev[n];
      setv[4] = out_tok_ev[n] & ~ep_enabled[n];
      setv[6] = (n == 0) ? b2b_hit : 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat[n]     <= '0;
        bus_seen[n] <= 1'b0;
        usb_seen[n] <= 1'b0;
      end else begin
        stat[n]     <= (stat[n] & ~clrv) | setv;
        bus_seen[n] <= xfer ? 1'b0 : (bus_seen[n] | xfer_bus_done[n]);
        usb_seen[n] <= xfer ? 1'b0 : (usb_seen[n] | xfer_usb_done[n]);
      end
    end

    assign sum[n] = (|stat[n]) & msk[n];
    assign stat_flat[n*7 +: 7] = stat[n];
  end

  assign out_irq = |sum;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(SUM_ADDR)) reg_rdata[SUM_LSB +: N_EP] = sum;
    if (reg_addr == ADDR_W'(MSK_ADDR)) reg_rdata[SUM_LSB +: N_EP] = msk;
    for (int n = 0; n < N_EP; n++)
      if (reg_addr == ADDR_W'(EP_BASE + n * EP_STRIDE))
        reg_rdata = {24'h0, 1'b1, stat[n]};
  end
endmodule

module out_ep_irq_rollup_chk #(
  parameter int N_EP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EP-1:0]   ep_enabled,
  input logic [N_EP-1:0]   ep_disabled_ev,
  input logic [N_EP-1:0]   out_tok_ev,
  input logic              ctl_setup_ev,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic              out_irq,
  input logic [N_EP*7-1:0] stat_flat
);
  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr || reg_wdata[6:0] == 7'b0) |=> ((stat_flat & $past(stat_flat)) == $past(stat_flat)));

  // R3
  ep_off_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_disabled_ev[0] |=> stat_flat[1]);

  // R6
  otep_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flat[4]) |-> $past(out_tok_ev[0] && !ep_enabled[0]));

  // R7
  b2b_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flat[6]) |-> $past(ctl_setup_ev));

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_irq) |-> $past(reg_wr));
endmodule

bind out_ep_irq_rollup out_ep_irq_rollup_chk #(.N_EP(N_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ep_enabled(ep_enabled), .ep_disabled_ev(ep_disabled_ev),
  .out_tok_ev(out_tok_ev), .ctl_setup_ev(ctl_setup_ev), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .out_irq(out_irq), .stat_flat(stat_flat)
);

// File: tb/out_ep_irq_rollup_bench.sv
`timescale 1ns/1ps
module out_ep_irq_rollup_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ep_enabled = '0, xfer_bus_done = '0, xfer_usb_done = '0;
  logic [3:0]  ep_disabled_ev = '0, setup_end_ev = '0, out_tok_ev = '0;
  logic        ctl_setup_ev = 1'b0, ctl_other_tok_ev = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        out_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  out_ep_irq_rollup u_out_ep_irq_rollup (.*);

  function automatic logic [11:0] ep_a(int n);
    return 12'hB08 + 12'(n * 'h20);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic setup_pulse();
    @(negedge clk); ctl_setup_ev = 1'b1;
    @(negedge clk); ctl_setup_ev = 1'b0;
  endtask

  task automatic t_reset();
    for (int n = 0; n < 4; n++) rd_chk("R1 ep word", ep_a(n), 32'h80);
    rd_chk("R1 summary", 12'h818, 32'h0);
    rd_chk("R1 mask", 12'h81C, 32'h0);
    chk("R1 out_irq", {31'b0, out_irq}, 32'h0);
  endtask

  task automatic t_xfer();
    @(negedge clk); xfer_bus_done = 4'b0010;
    @(negedge clk); xfer_bus_done = '0;
    rd_chk("R2 bus half only", ep_a(1), 32'h80);
    @(negedge clk); xfer_usb_done = 4'b0010;
    @(negedge clk); xfer_usb_done = '0;
    rd_chk("R2 both halves", ep_a(1), 32'h81);
    @(negedge clk); xfer_bus_done = 4'b0100; xfer_usb_done = 4'b0100;
    @(negedge clk); xfer_bus_done = '0; xfer_usb_done = '0;
    rd_chk("R2 same cycle", ep_a(2), 32'h81);
    wr(ep_a(1), 32'h1); wr(ep_a(2), 32'h1);
    rd_chk("R4 clear ep1", ep_a(1), 32'h80);
    rd_chk("R4 clear ep2", ep_a(2), 32'h80);
  endtask

  task automatic t_flags();
    @(negedge clk); ep_disabled_ev = 4'b1000; setup_end_ev = 4'b1000;
    @(negedge clk); ep_disabled_ev = '0; setup_end_ev = '0;
    rd_chk("R3 disabled+setup end", ep_a(3), 32'h8A);
    wr(ep_a(3), 32'h0);
    rd_chk("R4 zero write", ep_a(3), 32'h8A);
    wr(ep_a(2), 32'hFFFF_FFFF);
    rd_chk("R4 other address", ep_a(3), 32'h8A);
    wr(ep_a(3), 32'h2);
    rd_chk("R4 partial clear", ep_a(3), 32'h88);
    wr(ep_a(3), 32'hA4);
    rd_chk("R4 reserved bits", ep_a(3), 32'h88);
    wr(ep_a(3), 32'h8);
    rd_chk("R4 full clear", ep_a(3), 32'h80);
  endtask

  task automatic t_collide();
    @(negedge clk); ep_disabled_ev = 4'b0001;
    @(negedge clk); ep_disabled_ev = '0;
    @(negedge clk); ep_disabled_ev = 4'b0001; reg_addr = ep_a(0); reg_wdata = 32'h2; reg_wr = 1'b1;
    @(negedge clk); ep_disabled_ev = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd_chk("R5 set wins", ep_a(0), 32'h82);
    wr(ep_a(0), 32'h2);
    rd_chk("R5 later clear", ep_a(0), 32'h80);
  endtask

  task automatic t_otep();
    @(negedge clk); ep_enabled = 4'b0010; out_tok_ev = 4'b0011;
    @(negedge clk); out_tok_ev = '0;
    rd_chk("R6 disabled ep0", ep_a(0), 32'h90);
    rd_chk("R6 enabled ep1", ep_a(1), 32'h80);
    wr(ep_a(0), 32'h10);
    ep_enabled = '0;
  endtask

  task automatic t_b2b();
    for (int i = 0; i < 3; i++) setup_pulse();
    rd_chk("R7 three setups", ep_a(0), 32'h80);
    setup_pulse();
    rd_chk("R7 fourth setup", ep_a(0), 32'hC0);
    rd_chk("R7 ep1 bit6", ep_a(1), 32'h80);
    wr(ep_a(0), 32'h40);
    @(negedge clk); ctl_other_tok_ev = 1'b1;
    @(negedge clk); ctl_other_tok_ev = 1'b0;
    for (int i = 0; i < 2; i++) setup_pulse();
    @(negedge clk); ctl_other_tok_ev = 1'b1;
    @(negedge clk); ctl_other_tok_ev = 1'b0;
    for (int i = 0; i < 3; i++) setup_pulse();
    rd_chk("R8 other token restart", ep_a(0), 32'h80);
    @(negedge clk); setup_end_ev = 4'b0001;
    @(negedge clk); setup_end_ev = '0;
    for (int i = 0; i < 3; i++) setup_pulse();
    rd_chk("R8 setup end restart", ep_a(0), 32'h88);
    setup_pulse();
    rd_chk("R8 fourth after restart", ep_a(0), 32'hC8);
    wr(ep_a(0), 32'h48);
    rd_chk("R7 cleared", ep_a(0), 32'h80);
  endtask

  task automatic t_sum();
    @(negedge clk); ep_disabled_ev = 4'b0100;
    @(negedge clk); ep_disabled_ev = '0;
    rd_chk("R9 masked summary", 12'h818, 32'h0);
    chk("R9 masked irq", {31'b0, out_irq}, 32'h0);
    wr(12'h81C, 32'h0006_0000);
    rd_chk("R9 mask readback", 12'h81C, 32'h0006_0000);
    rd_chk("R9 summary", 12'h818, 32'h0004_0000);
    chk("R9 irq high", {31'b0, out_irq}, 32'h1);
    wr(ep_a(2), 32'h2);
    chk("R9 irq after clear", {31'b0, out_irq}, 32'h0);
    rd_chk("R9 summary after clear", 12'h818, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_xfer();
    t_flags();
    t_collide();
    t_otep();
    t_b2b();
    t_sum();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule